// File: doc/BRIEF.md
# Audio frame-sync pulse generator

This block produces the frame-sync pulse of a serial audio port. It counts bit clocks and, once per frame, drives a sync pulse of programmable width onto a transmit line and a receive line. It also emits a frame-start strobe that tells the downstream serializers where a frame begins. The bit clock comes from one of two sources: an internal divider of the system clock, or an external bit-clock input. The external input is synchronized, and its rising edges become bit-clock ticks. All logic runs on the system clock and advances only on bit-clock ticks.

A run enable holds the divider, the counters and the pending-write flag in reset while it is low. A second enable gates the sync lines and the strobe without stopping the counting, so the bit clock and frame phase keep running while no frames are emitted. In free-running mode a frame starts every period. In write-triggered mode a frame starts only after a data-register write strobe. One such frame runs per write, and a write taken during a frame makes the next frame follow with no gap. The frame period and the pulse width are each given as a field plus one, in bit clocks. A width larger than the period is clamped to the period. A polarity bit selects active-low sync.

The sequencer has three states, and every transition happens on a bit-clock tick. IDLE goes to PULSE when the mode is free-running or a write is pending. PULSE goes to GAP when the count passes the clamped width. GAP stays in GAP until the end of the period. At the end of a period, PULSE or GAP goes back to PULSE when a new frame is due, or returns to IDLE otherwise. A low run enable forces IDLE from any state.

Top module: `afs_gen`

## Requirements
- R1: In free-running mode (`auto_mode`=1), consecutive frame starts are `period_m1`+1 bit clocks apart.
- R2: The sync pulse is active from the first bit clock of each period for `width_m1`+1 bit clocks when `width_m1` <= `period_m1`.
- R3: When `width_m1` > `period_m1`, the active time is clamped to `period_m1`+1 bit clocks, which is the whole period.
- R4: In write-triggered mode (`auto_mode`=0), no frame starts without a `data_wr` strobe. Each write starts exactly one frame at the next bit clock, and a write taken during a frame starts another frame directly after it.
- R5: While `gen_en` is 0, there are no bit-clock ticks, the sync lines sit at the inactive level and `frame_start` is 0. After `gen_en` rises, the first bit clock begins a new frame.
- R6: While `fs_en` is 0, both sync lines are at the inactive level and `frame_start` is 0, but frame counting continues in phase.
- R7: With `fs_pol`=1 the sync lines are active low (active = 0). With `fs_pol`=0 they are active high.
- R8: With `clk_sel`=1, each rising edge of `ext_bclk` (synchronized) gives one bit-clock tick. `fs_tx` and `fs_rx` always carry the same value.
- R9: `frame_start` is asserted for exactly the first bit clock of each period.
- R10: With `clk_sel`=0, a one-cycle `bit_tick` occurs every `div_m1`+1 system clocks.
- R11: After reset, `bit_tick`, `frame_start`, `fs_tx` and `fs_rx` are all 0 (`fs_pol`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_en | input | 1 | Run enable; low holds the generator in reset |
| fs_en | input | 1 | Frame-sync output enable |
| clk_sel | input | 1 | 0: internal divider, 1: external bit clock |
| ext_bclk | input | 1 | External bit-clock input |
| div_m1 | input | DIVW | Internal divider ratio minus one |
| period_m1 | input | CNTW | Frame period minus one, in bit clocks |
| width_m1 | input | CNTW | Pulse width minus one, in bit clocks |
| fs_pol | input | 1 | 1: active-low sync |
| auto_mode | input | 1 | 1: free-running, 0: one frame per write |
| data_wr | input | 1 | Data-register write strobe |
| bit_tick | output | 1 | One-cycle bit-clock tick |
| fs_tx | output | 1 | Transmit frame-sync line |
| fs_rx | output | 1 | Receive frame-sync line |
| frame_start | output | 1 | High during the first bit clock of a frame |

## Verification
The hardest cases to reach are in write-triggered mode. One is a write taken while a frame is in progress: it must chain a second frame at the period boundary. Another is a run with no writes at all, where the sequencer must stay idle indefinitely. The stimulus issues a lone write, then a second write a few cycles into the first frame, and counts frame starts over long windows. A reference model advances on every observed tick and checks both lines and the strobe each cycle. The frame-sync enable is also dropped and restored mid-frame, so the model confirms that the phase kept counting.

// File: rtl/afs_pkg.sv
package afs_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_PULSE = 2'd1,
        FS_GAP   = 2'd2
    } fs_state_e;

    localparam int NUM_FS_LINES = 2;

endpackage

// File: rtl/afs_clk_src.sv
module afs_clk_src #(
    parameter int DIVW        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gen_en,
    input  logic            clk_sel,
    input  logic            ext_bclk,
    input  logic [DIVW-1:0] div_m1,
    output logic            tick
);

    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] sync_q;
    logic [DIVW-1:0]  dcnt_q;
    logic             tick_q;
    logic             ext_rise;

    // synchronizer chain plus one edge-detect stage
    genvar gi;
    generate
        for (gi = 0; gi < CHAIN; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ext_bclk;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    assign ext_rise = sync_q[CHAIN-2] & ~sync_q[CHAIN-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt_q <= '0;
            tick_q <= 1'b0;
        end else if (!gen_en) begin
            dcnt_q <= '0;
            tick_q <= 1'b0;
        end else if (clk_sel) begin
            dcnt_q <= '0;
            tick_q <= ext_rise;
        end else if (dcnt_q == div_m1) begin
            dcnt_q <= '0;
            tick_q <= 1'b1;
        end else begin
            dcnt_q <= dcnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    // R10: a divided tick with ratio above one is never followed by another
    a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q && !clk_sel && div_m1 != '0) |=> (!tick_q || clk_sel));

    // R8: an external edge yields a single-cycle tick
    a_r8_ext_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q && clk_sel) |=> (!tick_q || !clk_sel));

    // R5: no tick while the generator is held
    a_r5_no_tick_held: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !tick_q);

endmodule

// File: rtl/afs_seq.sv
module afs_seq
    import afs_pkg::*;
#(
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gen_en,
    input  logic            tick,
    input  logic            auto_mode,
    input  logic            data_wr,
    input  logic [CNTW-1:0] period_m1,
    input  logic [CNTW-1:0] width_m1,
    output logic            fs_active,
    output logic            fstart
);

    fs_state_e       state_q, state_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic            pend_q, pend_d;
    logic            fstart_q, fstart_d;
    logic [CNTW-1:0] width_eff;
    logic [CNTW-1:0] cnt_inc;
    logic            go;

    assign width_eff = (width_m1 > period_m1) ? period_m1 : width_m1;
    assign cnt_inc   = cnt_q + 1'b1;
    assign go        = auto_mode | pend_q;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        fstart_d = fstart_q;
        pend_d   = pend_q | data_wr;
        if (tick) begin
            fstart_d = 1'b0;
            unique case (state_q)
                FS_IDLE: begin
                    if (go) begin
                        state_d  = FS_PULSE;
                        cnt_d    = '0;
                        fstart_d = 1'b1;
                        pend_d   = data_wr;
                    end
                end
                FS_PULSE, FS_GAP: begin
                    if (cnt_q == period_m1) begin
                        cnt_d = '0;
                        if (go) begin
                            state_d  = FS_PULSE;
                            fstart_d = 1'b1;
                            pend_d   = data_wr;
                        end else begin
                            state_d = FS_IDLE;
                        end
                    end else begin
                        cnt_d   = cnt_inc;
                        state_d = (cnt_inc <= width_eff) ? FS_PULSE : FS_GAP;
                    end
                end
                default: begin
                    state_d = FS_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FS_IDLE;
            cnt_q    <= '0;
            pend_q   <= 1'b0;
            fstart_q <= 1'b0;
        end else if (!gen_en) begin
            state_q  <= FS_IDLE;
            cnt_q    <= '0;
            pend_q   <= 1'b0;
            fstart_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            pend_q   <= pend_d;
            fstart_q <= fstart_d;
        end
    end

    // outputs
    always_comb begin
        fs_active = (state_q == FS_PULSE);
        fstart    = fstart_q;
    end

    // R9: the strobe only marks the first count of a pulse
    a_r9_start_first: assert property (@(posedge clk) disable iff (!rst_n)
        fstart_q |-> (state_q == FS_PULSE && cnt_q == '0));

    // R5: a held generator is idle on the next cycle
    a_r5_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (state_q == FS_IDLE && !fstart_q && cnt_q == '0));

    // R4: idle with nothing pending and no free run cannot start a frame
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_IDLE && !auto_mode && !pend_q) |=> (state_q != FS_PULSE));

    // R2: the pulse state never holds a count past the clamped width
    a_r2_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_PULSE && $stable(width_m1) && $stable(period_m1)) |-> (cnt_q <= width_eff));

endmodule

// File: rtl/afs_out.sv
module afs_out #(
    parameter int NUM_LINES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fs_active,
    input  logic                 fstart,
    input  logic                 fs_en,
    input  logic                 fs_pol,
    output logic [NUM_LINES-1:0] fs_lines,
    output logic                 frame_start
);

    logic gated;

    assign gated       = fs_active & fs_en;
    assign frame_start = fstart & fs_en;

    genvar li;
    generate
        for (li = 0; li < NUM_LINES; li++) begin : g_line
            assign fs_lines[li] = gated ^ fs_pol;
        end
    endgenerate

    // R6: a disabled output never strobes
    a_r6_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_en |-> !frame_start);

    // R9: a strobe always coincides with an active pulse on every line
    a_r9_strobe_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (fs_lines == {NUM_LINES{~fs_pol}}));

endmodule

// File: rtl/afs_gen.sv
module afs_gen
    import afs_pkg::*;
#(
    parameter int DIVW        = 4,
    parameter int CNTW        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gen_en,
    input  logic            fs_en,
    input  logic            clk_sel,
    input  logic            ext_bclk,
    input  logic [DIVW-1:0] div_m1,
    input  logic [CNTW-1:0] period_m1,
    input  logic [CNTW-1:0] width_m1,
    input  logic            fs_pol,
    input  logic            auto_mode,
    input  logic            data_wr,
    output logic            bit_tick,
    output logic            fs_tx,
    output logic            fs_rx,
    output logic            frame_start
);

    logic                    tick;
    logic                    fs_active;
    logic                    fstart;
    logic [NUM_FS_LINES-1:0] fs_lines;

    afs_clk_src #(
        .DIVW        (DIVW),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clk_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_en   (gen_en),
        .clk_sel  (clk_sel),
        .ext_bclk (ext_bclk),
        .div_m1   (div_m1),
        .tick     (tick)
    );

    afs_seq #(
        .CNTW (CNTW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_en    (gen_en),
        .tick      (tick),
        .auto_mode (auto_mode),
        .data_wr   (data_wr),
        .period_m1 (period_m1),
        .width_m1  (width_m1),
        .fs_active (fs_active),
        .fstart    (fstart)
    );

    afs_out #(
        .NUM_LINES (NUM_FS_LINES)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_active   (fs_active),
        .fstart      (fstart),
        .fs_en       (fs_en),
        .fs_pol      (fs_pol),
        .fs_lines    (fs_lines),
        .frame_start (frame_start)
    );

    assign bit_tick = tick;
    assign fs_tx    = fs_lines[0];
    assign fs_rx    = fs_lines[NUM_FS_LINES-1];

    // R8: both sync lines agree at all times
    a_r8_lines_match: assert property (@(posedge clk) disable iff (!rst_n)
        fs_tx == fs_rx);

    // R5: a held generator drives the inactive level
    a_r5_held_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!gen_en) && !gen_en |-> (fs_tx == fs_pol && !frame_start));

endmodule

// File: tb/afs_gen_tb.sv
module afs_gen_tb_top;

    localparam int DIVW = 4;
    localparam int CNTW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            gen_en = 1'b0;
    logic            fs_en = 1'b0;
    logic            clk_sel = 1'b0;
    logic            ext_bclk = 1'b0;
    logic [DIVW-1:0] div_m1 = '0;
    logic [CNTW-1:0] period_m1 = '0;
    logic [CNTW-1:0] width_m1 = '0;
    logic            fs_pol = 1'b0;
    logic            auto_mode = 1'b1;
    logic            data_wr = 1'b0;
    logic            bit_tick, fs_tx, fs_rx, frame_start;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    bit ext_run = 0;

    always #2.5 clk = ~clk;

    afs_gen #(.DIVW(DIVW), .CNTW(CNTW)) dut_i (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .fs_en(fs_en),
        .clk_sel(clk_sel), .ext_bclk(ext_bclk), .div_m1(div_m1),
        .period_m1(period_m1), .width_m1(width_m1), .fs_pol(fs_pol),
        .auto_mode(auto_mode), .data_wr(data_wr), .bit_tick(bit_tick),
        .fs_tx(fs_tx), .fs_rx(fs_rx), .frame_start(frame_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // scoreboard: model pushes expected item, compared one cycle later
    typedef struct { int st; bit fst; } exp_t;
    exp_t q[$];
    int   m_st = 0;
    int   m_cnt = 0;
    bit   m_pend = 0;
    bit   m_fst = 0;

    // measurement state
    int cyc = 0;
    int last_tick_cyc = 0;
    int tick_gap = 0;
    int tick_total = 0;
    bit tick_prev = 0;
    int run_cnt = 0;
    int hi_cnt = 0;
    int last_period = 0;
    int last_width = 0;
    int starts_total = 0;
    int active_total = 0;

    always @(negedge clk) begin
        exp_t e;
        int wm;
        bit go;
        bit act_now;
        cyc++;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk("R7 fs_tx", int'(fs_tx), int'(((e.st == 1) && fs_en) ^ fs_pol));
            chk("R8 fs_rx", int'(fs_rx), int'(fs_tx));
            chk("R9 frame_start", int'(frame_start), int'(e.fst && fs_en));
        end
        // interval measurement after each consumed tick
        act_now = fs_tx ^ fs_pol;
        if (tick_prev) begin
            if (frame_start) begin
                last_period = run_cnt;
                last_width  = hi_cnt;
                run_cnt = 1;
                hi_cnt  = act_now ? 1 : 0;
                starts_total++;
            end else begin
                run_cnt++;
                if (act_now) hi_cnt++;
            end
            if (act_now) active_total++;
        end
        tick_prev = bit_tick;
        if (bit_tick) begin
            tick_gap = cyc - last_tick_cyc;
            last_tick_cyc = cyc;
            tick_total++;
        end
        // model next state
        wm = (int'(width_m1) > int'(period_m1)) ? int'(period_m1) : int'(width_m1);
        go = auto_mode | m_pend;
        if (!rst_n || !gen_en) begin
            m_st = 0; m_cnt = 0; m_pend = 0; m_fst = 0;
        end else if (bit_tick) begin
            m_fst = 0;
            if (m_st == 0) begin
                if (go) begin m_st = 1; m_cnt = 0; m_fst = 1; m_pend = data_wr; end
                else m_pend = m_pend | data_wr;
            end else if (m_cnt == int'(period_m1)) begin
                m_cnt = 0;
                if (go) begin m_st = 1; m_fst = 1; m_pend = data_wr; end
                else begin m_st = 0; m_pend = m_pend | data_wr; end
            end else begin
                m_cnt++;
                m_st = (m_cnt <= wm) ? 1 : 2;
                m_pend = m_pend | data_wr;
            end
        end else begin
            m_pend = m_pend | data_wr;
        end
        e.st = m_st;
        e.fst = m_fst;
        if (rst_n) q.push_back(e);
    end

    always begin
        @(posedge clk); #1;
        if (ext_run) begin
            repeat (2) begin @(posedge clk); #1; end
            ext_bclk = ~ext_bclk;
        end
    end

    task automatic cycles(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic write_pulse();
        data_wr = 1'b1;
        cycles(1);
        data_wr = 1'b0;
    endtask

    initial begin
        int s0, a0, t0;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        // R11 reset state
        chk("R11 bit_tick", int'(bit_tick), 0);
        chk("R11 frame_start", int'(frame_start), 0);
        chk("R11 fs_tx", int'(fs_tx), 0);
        chk("R11 fs_rx", int'(fs_rx), 0);

        // free-running, 8-clock frame, 3-clock pulse
        div_m1 = 4'd1; period_m1 = 8'd7; width_m1 = 8'd2;
        fs_en = 1'b1; auto_mode = 1'b1; gen_en = 1'b1;
        cycles(100);
        chk("R1 period", last_period, 8);
        chk("R2 width", last_width, 3);
        chk("R10 gap div2", tick_gap, 2);

        // active-low
        fs_pol = 1'b1;
        cycles(100);
        chk("R7 width low", last_width, 3);
        chk("R1 period low", last_period, 8);
        fs_pol = 1'b0;

        // clamp
        width_m1 = 8'd12;
        cycles(100);
        chk("R3 clamp width", last_width, 8);
        width_m1 = 8'd4;
        cycles(60);
        chk("R2 width 5", last_width, 5);

        // output gating with counting kept
        cycles(5);
        fs_en = 1'b0;
        s0 = starts_total; a0 = active_total;
        cycles(100);
        chk("R6 no starts", starts_total - s0, 0);
        chk("R6 no active", active_total - a0, 0);
        cycles(3);
        fs_en = 1'b1;
        cycles(60);
        chk("R6 width after", last_width, 5);

        // run enable low
        gen_en = 1'b0;
        cycles(10);
        chk("R5 held fs_tx", int'(fs_tx), 0);
        chk("R5 held tick", int'(bit_tick), 0);
        chk("R5 held start", int'(frame_start), 0);
        s0 = starts_total; t0 = tick_total;
        cycles(20);
        chk("R5 no ticks held", tick_total - t0, 0);
        gen_en = 1'b1;
        cycles(5);
        chk("R5 restart frame", starts_total - s0, 1);
        cycles(40);

        // write-triggered
        gen_en = 1'b0;
        auto_mode = 1'b0;
        cycles(3);
        gen_en = 1'b1;
        s0 = starts_total;
        cycles(100);
        chk("R4 no write idle", starts_total - s0, 0);
        write_pulse();
        cycles(40);
        chk("R4 one frame", starts_total - s0, 1);
        s0 = starts_total;
        write_pulse();
        cycles(6);
        write_pulse();
        cycles(60);
        chk("R4 chained frames", starts_total - s0, 2);
        auto_mode = 1'b1;

        // slower divider
        div_m1 = 4'd3;
        cycles(60);
        chk("R10 gap div4", tick_gap, 4);
        chk("R1 period div4", last_period, 8);

        // external bit clock: rising edge every 6 system clocks
        clk_sel = 1'b1;
        ext_run = 1'b1;
        cycles(30);
        t0 = tick_total;
        cycles(120);
        chk("R8 ext tick count ok", ((tick_total - t0) >= 19 && (tick_total - t0) <= 21) ? 1 : 0, 1);
        cycles(120);
        chk("R8 ext period", last_period, 8);
        chk("R8 ext width", last_width, 5);
        ext_run = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule